// File: doc/BRIEF.md
# Chained Readout Token Node

This block is one link in a chain of readout nodes that take turns on a shared output bus. A token travels along the chain on a single enable wire. While a node holds the token, it places its buffered words on the bus, one word per readout tick. A word is selected in one tick and driven in the next. The node passes the token on early: the enable to the next node rises in the same tick in which the node selects its own last word. The next node therefore selects its first word while this node is still driving its last one, and the bus carries back-to-back words across the hand-over.

The number of words per node is set by an input. A typical event carries two words per node. Any count from zero to the buffer depth is legal, and larger values are clamped to the depth. A node with no words still keeps the token for one whole tick before passing it on, so the bus is left idle for that tick. When the chain's first enable is dropped, every node's outgoing enable falls in the same clock cycle through combinational logic, and every node returns to idle.

Internally a controller moves through three states. `ST_IDLE` waits for the token. `ST_SEND` walks the word index. `ST_PASSED` means the last word has been selected and the token has gone on. The transitions are:
- `ST_IDLE` to `ST_SEND` on a tick with the token held and a nonzero count.
- `ST_IDLE` to `ST_PASSED` on a tick with the token held and a zero count.
- `ST_SEND` to `ST_SEND` on a tick while words remain to select.
- `ST_SEND` to `ST_PASSED` on the tick that drives the last word.
- Any state to `ST_IDLE` in any cycle with the incoming enable low.

Top module: `readout_token_node`

## Requirements
- R1: While reset is asserted and after it is released, `bus_drive`, `bus_word` and `chain_out` are all zero until a tick sees `chain_in` high.
- R2: Call the first tick with `chain_in` high tick 1. Tick 1 only selects word 0 and drives nothing. After tick j, for j from 2 to N+1, `bus_drive` is high and `bus_word` holds buffer word j-2, where word i sits at `word_buf[i*WORD_W +: WORD_W]`. After tick N+2, `bus_drive` is low.
- R3: For a count N of two or more, `chain_out` goes high after tick N, which is the tick that drives word N-2 and selects word N-1. It stays high while `chain_in` stays high.
- R4: For a count of one, `chain_out` goes high after tick 1.
- R5: For a count of zero, `chain_out` goes high after tick 1 and `bus_drive` never rises.
- R6: When `chain_in` goes low, `chain_out` is low in the same clock cycle.
- R7: In the clock after a cycle with `chain_in` low, `bus_drive` is low and the node is idle. A later rise of `chain_in` starts over from word 0, even if an earlier sequence was cut short.
- R8: `bus_word` is all zeros whenever `bus_drive` is low.
- R9: A `word_count` above `MAX_WORDS` behaves exactly like `MAX_WORDS`.
- R10: While `chain_in` is high, `bus_word` and `bus_drive` change only at clock edges where `tick_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-clock pulse marking each readout tick |
| chain_in | input | 1 | Token from the previous node (enable in) |
| word_count | input | CNT_W | Number of words to send this event |
| word_buf | input | MAX_WORDS*WORD_W | Buffered words; word i at bits i*WORD_W upward |
| bus_word | output | WORD_W | Word driven onto the shared bus, zero when idle |
| bus_drive | output | 1 | High in the ticks in which this node owns the bus |
| chain_out | output | 1 | Token to the next node (enable out) |

## Verification
The bench tracks the tick in which the token is handed on for counts of zero, one, two and the full depth. A design that passed the token late would leave a one-tick hole between nodes. A design that passed it one tick too early would let two nodes drive the bus at once. The count of zero is checked for a node that forwards the token in the same cycle it arrives instead of holding it for a full tick. A count above the depth is checked for a node that reads past its buffer. An abort in the middle of a sequence is checked for a node that resumes from a stale index instead of word 0. A three-node chain with counts 2, 0 and 1 checks the exact bus sequence, including the idle tick left by the empty node.

// File: rtl/token_node_pkg.sv
package token_node_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SEND   = 2'd1,
        ST_PASSED = 2'd2
    } node_state_e;

endpackage

// File: rtl/count_clamp.sv
module count_clamp #(
    parameter int MAX_WORDS = 4,
    parameter int CNT_W     = 3
) (
    input  logic [CNT_W-1:0] raw_count,
    output logic [CNT_W-1:0] eff_count
);

    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_WORDS);

    always_comb begin
        if (raw_count > LIMIT) begin
            eff_count = LIMIT;
        end else begin
            eff_count = raw_count;
        end
    end

endmodule

// File: rtl/word_mux.sv
module word_mux #(
    parameter int MAX_WORDS = 4,
    parameter int WORD_W    = 16,
    parameter int IDX_W     = 2
) (
    input  logic [MAX_WORDS*WORD_W-1:0] word_buf,
    input  logic [IDX_W-1:0]            sel_idx,
    output logic [WORD_W-1:0]           sel_word
);

    logic [WORD_W-1:0] slots [MAX_WORDS];

    for (genvar g = 0; g < MAX_WORDS; g++) begin : g_slot
        assign slots[g] = word_buf[g*WORD_W +: WORD_W];
    end

    always_comb begin
        sel_word = '0;
        for (int k = 0; k < MAX_WORDS; k++) begin
            if (sel_idx == IDX_W'(k)) begin
                sel_word = slots[k];
            end
        end
    end

endmodule

// File: rtl/token_fsm.sv
module token_fsm
    import token_node_pkg::*;
#(
    parameter int CNT_W = 3,
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             chain_in,
    input  logic [CNT_W-1:0] eff_count,
    output logic [IDX_W-1:0] sel_idx,
    output logic             load_word,
    output logic             end_drive,
    output logic             pass_q
);

    node_state_e state, nxt;
    logic [CNT_W-1:0] idx_ext;
    logic [CNT_W-1:0] idx_next;
    logic             at_last;
    logic             next_is_last;

    assign idx_ext      = CNT_W'(sel_idx);
    assign idx_next     = idx_ext + CNT_W'(1);
    assign at_last      = (idx_next == eff_count);
    assign next_is_last = (idx_next == eff_count - CNT_W'(1));

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (eff_count == '0) nxt = ST_PASSED;
                else                 nxt = ST_SEND;
            end
            ST_SEND: begin
                if (at_last) nxt = ST_PASSED;
            end
            ST_PASSED: nxt = ST_PASSED;
            default:   nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n || !chain_in) begin
            state <= ST_IDLE;
        end else if (tick_en) begin
            state <= nxt;
        end
    end

    // output / index registers
    always_ff @(posedge clk) begin
        if (!rst_n || !chain_in) begin
            sel_idx <= '0;
            pass_q  <= 1'b0;
        end else if (tick_en) begin
            unique case (state)
                ST_IDLE: begin
                    sel_idx <= '0;
                    pass_q  <= (eff_count <= CNT_W'(1));
                end
                ST_SEND: begin
                    if (!at_last) begin
                        sel_idx <= IDX_W'(idx_next);
                        if (next_is_last) pass_q <= 1'b1;
                    end
                end
                ST_PASSED: pass_q <= 1'b1;
                default:   pass_q <= 1'b0;
            endcase
        end
    end

    assign load_word = tick_en && chain_in && (state == ST_SEND);
    assign end_drive = !chain_in || (tick_en && (state == ST_PASSED));

    AST_PASSED_HOLDS_TOKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PASSED) |-> pass_q); // R3
    AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SEND) |-> (idx_ext < eff_count)); // R9
    AST_IDLE_ON_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !chain_in |=> (state == ST_IDLE && !pass_q)); // R7

endmodule

// File: rtl/word_driver.sv
module word_driver #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_word,
    input  logic              end_drive,
    input  logic [WORD_W-1:0] sel_word,
    output logic [WORD_W-1:0] bus_word,
    output logic              bus_drive
);

    always_ff @(posedge clk) begin
        if (!rst_n || end_drive) begin
            bus_word  <= '0;
            bus_drive <= 1'b0;
        end else if (load_word) begin
            bus_word  <= sel_word;
            bus_drive <= 1'b1;
        end
    end

    AST_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_drive |-> (bus_word == '0)); // R8

endmodule

// File: rtl/readout_token_node.sv
module readout_token_node #(
    parameter int MAX_WORDS = 4,
    parameter int WORD_W    = 16,
    parameter int CNT_W     = $clog2(MAX_WORDS + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        tick_en,
    input  logic                        chain_in,
    input  logic [CNT_W-1:0]            word_count,
    input  logic [MAX_WORDS*WORD_W-1:0] word_buf,
    output logic [WORD_W-1:0]           bus_word,
    output logic                        bus_drive,
    output logic                        chain_out
);

    localparam int IDX_W = (MAX_WORDS > 1) ? $clog2(MAX_WORDS) : 1;

    logic [CNT_W-1:0]  eff_count;
    logic [IDX_W-1:0]  sel_idx;
    logic [WORD_W-1:0] sel_word;
    logic              load_word;
    logic              end_drive;
    logic              pass_q;

    count_clamp #(.MAX_WORDS(MAX_WORDS), .CNT_W(CNT_W)) u_clamp (
        .raw_count (word_count),
        .eff_count (eff_count)
    );

    token_fsm #(.CNT_W(CNT_W), .IDX_W(IDX_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .chain_in  (chain_in),
        .eff_count (eff_count),
        .sel_idx   (sel_idx),
        .load_word (load_word),
        .end_drive (end_drive),
        .pass_q    (pass_q)
    );

    word_mux #(.MAX_WORDS(MAX_WORDS), .WORD_W(WORD_W), .IDX_W(IDX_W)) u_mux (
        .word_buf (word_buf),
        .sel_idx  (sel_idx),
        .sel_word (sel_word)
    );

    word_driver #(.WORD_W(WORD_W)) u_drv (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_word (load_word),
        .end_drive (end_drive),
        .sel_word  (sel_word),
        .bus_word  (bus_word),
        .bus_drive (bus_drive)
    );

    // token release follows the incoming enable down without a clock
    assign chain_out = pass_q && chain_in;

    AST_DRIVE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_drive) |-> $past(tick_en)); // R10
    AST_STABLE_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && chain_in) |=> ($stable(bus_word) && $stable(bus_drive))); // R10

endmodule

// File: tb/readout_token_node_tb.sv
module readout_token_node_tb;

    localparam int MW   = 4;
    localparam int WW   = 16;
    localparam int CW   = $clog2(MW + 1);
    localparam int TDIV = 33;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_en = 1'b0;
    logic cin0 = 1'b0;
    logic [CW-1:0] cnt0 = '0, cnt1 = '0, cnt2 = '0;
    logic [MW*WW-1:0] buf0 = '0, buf1 = '0, buf2 = '0;
    logic [WW-1:0] bw0, bw1, bw2;
    logic dr0, dr1, dr2, co0, co1, co2;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    int tcnt    = 0;

    always #2 clk = ~clk;

    always @(negedge clk) begin
        if (tcnt == TDIV - 1) begin
            tcnt    <= 0;
            tick_en <= 1'b1;
        end else begin
            tcnt    <= tcnt + 1;
            tick_en <= 1'b0;
        end
    end

    readout_token_node #(.MAX_WORDS(MW), .WORD_W(WW)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .chain_in(cin0),
        .word_count(cnt0), .word_buf(buf0),
        .bus_word(bw0), .bus_drive(dr0), .chain_out(co0));
    readout_token_node #(.MAX_WORDS(MW), .WORD_W(WW)) u_n1 (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .chain_in(co0),
        .word_count(cnt1), .word_buf(buf1),
        .bus_word(bw1), .bus_drive(dr1), .chain_out(co1));
    readout_token_node #(.MAX_WORDS(MW), .WORD_W(WW)) u_n2 (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .chain_in(co1),
        .word_count(cnt2), .word_buf(buf2),
        .bus_word(bw2), .bus_drive(dr2), .chain_out(co2));

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run hung, actual cycles %0d expected < 150000", cyc);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic check(input bit ok, input string rq, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    function automatic logic [WW-1:0] wv(input int n, input int i);
        return WW'(32'hA000 + n * 16 + i);
    endfunction

    task automatic next_tick();
        @(posedge clk iff tick_en);
        @(negedge clk);
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        repeat (5) @(negedge clk);
        check(dr0 == 1'b0, "R1", "drive in reset", 32'(dr0), 0);
        check(bw0 == '0, "R1", "word in reset", 32'(bw0), 0);
        rst_n = 1'b1;
        next_tick();
        check(co0 == 1'b0 && dr0 == 1'b0, "R1", "idle after reset", 32'({co0, dr0}), 0);
    endtask

    task automatic run_single(input int n, input string rq_ceo);
        int eff;
        int thr;
        eff = (n > MW) ? MW : n;
        thr = (eff > 1) ? eff : 1;
        cnt0 = CW'(n);
        for (int i = 0; i < MW; i++) buf0[i*WW +: WW] = wv(n, i);
        next_tick();
        cin0 = 1'b1;
        for (int j = 1; j <= eff + 3; j++) begin
            bit edrv;
            logic [WW-1:0] ebus;
            next_tick();
            edrv = (j >= 2) && (j <= eff + 1);
            ebus = edrv ? wv(n, j - 2) : '0;
            check(dr0 == edrv, "R2", $sformatf("n=%0d drive after tick %0d", n, j), 32'(dr0), 32'(edrv));
            check(bw0 == ebus, edrv ? (n > MW ? "R9" : "R2") : "R8",
                  $sformatf("n=%0d word after tick %0d", n, j), 32'(bw0), 32'(ebus));
            check(co0 == (j >= thr), rq_ceo, $sformatf("n=%0d chain_out after tick %0d", n, j),
                  32'(co0), 32'(j >= thr));
            if (j == 2 && edrv) begin
                repeat (10) @(negedge clk);
                check(bw0 == ebus && dr0, "R10", "word held between ticks", 32'(bw0), 32'(ebus));
            end
        end
        cin0 = 1'b0;
        #1;
        check(co0 == 1'b0, "R6", "chain_out falls with chain_in", 32'(co0), 0);
        @(negedge clk);
        check(dr0 == 1'b0, "R7", "drive low after drop", 32'(dr0), 0);
    endtask

    task automatic test_abort();
        cnt0 = CW'(3);
        for (int i = 0; i < MW; i++) buf0[i*WW +: WW] = wv(3, i);
        next_tick();
        cin0 = 1'b1;
        next_tick();
        next_tick();
        check(dr0 && bw0 == wv(3, 0), "R2", "abort: first word", 32'(bw0), 32'(wv(3, 0)));
        cin0 = 1'b0;
        @(negedge clk);
        check(dr0 == 1'b0, "R7", "abort: drive cleared", 32'(dr0), 0);
        check(bw0 == '0, "R8", "abort: word zero", 32'(bw0), 0);
        next_tick();
        cin0 = 1'b1;
        next_tick();
        check(dr0 == 1'b0, "R7", "restart: tick 1 idle bus", 32'(dr0), 0);
        next_tick();
        check(bw0 == wv(3, 0), "R7", "restart from word 0", 32'(bw0), 32'(wv(3, 0)));
        cin0 = 1'b0;
        @(negedge clk);
    endtask

    task automatic test_chain();
        logic [WW-1:0] exp_w [1:6];
        cnt0 = CW'(2); cnt1 = CW'(0); cnt2 = CW'(1);
        for (int i = 0; i < MW; i++) begin
            buf0[i*WW +: WW] = wv(10, i);
            buf1[i*WW +: WW] = wv(11, i);
            buf2[i*WW +: WW] = wv(12, i);
        end
        exp_w[1] = '0; exp_w[2] = wv(10, 0); exp_w[3] = wv(10, 1);
        exp_w[4] = '0; exp_w[5] = wv(12, 0); exp_w[6] = '0;
        next_tick();
        cin0 = 1'b1;
        for (int j = 1; j <= 6; j++) begin
            logic [WW-1:0] busor;
            next_tick();
            busor = bw0 | bw1 | bw2;
            check($countones({dr0, dr1, dr2}) <= 1, "R2", $sformatf("chain single owner tick %0d", j),
                  32'({dr0, dr1, dr2}), 0);
            check(busor == exp_w[j], (j == 4) ? "R5" : "R3",
                  $sformatf("chain bus after tick %0d", j), 32'(busor), 32'(exp_w[j]));
        end
        check(dr1 == 1'b0 && co2 == 1'b1, "R5", "empty node passed token", 32'({dr1, co2}), 1);
        cin0 = 1'b0;
        #1;
        check({co0, co1, co2} == 3'b000, "R6", "chain drop ripples", 32'({co0, co1, co2}), 0);
        @(negedge clk);
    endtask

    initial begin
        test_reset();
        run_single(2, "R3");
        run_single(1, "R4");
        run_single(0, "R5");
        run_single(4, "R3");
        run_single(7, "R9");
        test_abort();
        test_chain();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule